// File: doc/BRIEF.md
# Store-Conditional Reservation Checker

This block settles whether a 32-bit conditional store may go ahead. It holds one reservation, made of a valid flag, a reserved real address and a reserved length in bytes. A separate reserve port records that reservation. For each conditional-store request, the block adds a base operand to an index operand to form the target address. It checks that address against the reservation. It then either issues a 4-byte write or suppresses it, returns a 4-bit condition result, and drops the reservation.

Target addresses are used directly as real addresses. There is one case where the address is not an exact match but falls in the same minimum-size page as the reservation. Two parameters fix what happens in that case: whether the write is issued, and which success bit is reported. The results appear one clock after the request and are marked by a done pulse.

Top module: `sc_resv_checker`

## Requirements
- R1: The target address is `index + base`. When the base register select `sc_base_sel_i` is zero, the base term is the constant 0 and `sc_base_i` has no effect.
- R2: The request succeeds exactly when three things hold: a reservation is valid, its length is 4, and its address equals the target address. On success, `wr_en_o` is 1, `wr_addr_o` is the target address and `wr_data_o` is bits [31:0] of `sc_src_i`.
- R3: `cr_o` is {2'b00, ok, so}. Bit 1 is the outcome bit. Bit 0 is `so_i` as sampled with the request.
- R4: If the reservation is valid and the test in R2 fails, and the page numbers differ (address bits above log2(PAGE_BYTES), default page 4096), then no write is issued and bit 1 is 0.
- R5: If no reservation is valid, no write is issued and bit 1 is 0.
- R6: If the reservation is valid and the test in R2 fails, but the page numbers are equal, then the write is issued only if AMB_STORE is set, and bit 1 equals AMB_FLAG. Both parameters default to 1.
- R7: Every request clears the reservation, whatever its outcome.
- R8: A reserve command sets the valid flag and loads the address and length in one clock. If it arrives in the same cycle as a request, the request is judged against the old state, and afterwards the new reservation stands.
- R9: The outputs are registered and appear one cycle after the request. `done_o` pulses for one cycle per request, and `wr_en_o` is only ever 1 together with `done_o`.
- R10: After reset, no reservation is held, and `done_o`, `wr_en_o` and `cr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rsv_set_i | input | 1 | Reserve command |
| rsv_addr_i | input | ADDR_W | Real address to reserve |
| rsv_len_i | input | LEN_W | Reserved length in bytes |
| sc_req_i | input | 1 | Conditional-store request |
| sc_base_sel_i | input | SEL_W | Base register select; zero forces a base of 0 |
| sc_base_i | input | ADDR_W | Base operand value |
| sc_index_i | input | ADDR_W | Index operand value |
| sc_src_i | input | DATA_W | Source operand; low 32 bits are stored |
| so_i | input | 1 | Current summary-overflow bit |
| wr_en_o | output | 1 | 4-byte write strobe |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | 32 | Write data |
| cr_o | output | 4 | Condition result |
| done_o | output | 1 | Result valid pulse |

## Verification
The hardest case to reach is a reserve command and a request in the same clock. In that case the request must be judged on the old reservation, while the new one must still be there afterwards. The stimulus first makes sure no reservation exists. It then issues both commands in one cycle and expects a failure. A follow-up request to the newly reserved address must then succeed. The same-page mismatch case is reached in two ways: by reserving with a length other than 4 at an exact address, and by reserving a correct length but storing to a neighbouring word in the same page. A reserve on the last word of one page, followed by a store to the next page, exercises the page boundary.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    SC_NONE      = 2'd0,
    SC_EXACT     = 2'd1,
    SC_SAME_PAGE = 2'd2,
    SC_OTHER_PG  = 2'd3
  } sc_case_e;
endpackage

// File: rtl/sc_resv_reg.sv
module sc_resv_reg #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic [LEN_W-1:0]  set_len_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      len_o   <= '0;
    end else if (set_i) begin
      // set wins over a same-cycle clear: request already used old state
      valid_o <= 1'b1;
      addr_o  <= set_addr_i;
      len_o   <= set_len_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_clear_after_sc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !valid_o);
  assert_set_after_lr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (valid_o && addr_o == $past(set_addr_i) && len_o == $past(set_len_i)));
endmodule

// File: rtl/sc_ea_calc.sv
module sc_ea_calc #(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 5
) (
  input  logic [SEL_W-1:0]  base_sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] base_term;
  always_comb begin
    base_term = (base_sel_i == '0) ? '0 : base_i;
    ea_o      = base_term + index_i;
  end
endmodule

// File: rtl/sc_match.sv
module sc_match
  import sc_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 4,
  parameter int PAGE_BYTES  = 4096,
  parameter int STORE_BYTES = 4
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] rsv_addr_i,
  input  logic [LEN_W-1:0]  rsv_len_i,
  input  logic [ADDR_W-1:0] ea_i,
  output sc_case_e          case_o
);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);

  logic exact, same_page;
  always_comb begin
    exact     = (rsv_len_i == LEN_W'(STORE_BYTES)) && (rsv_addr_i == ea_i);
    same_page = (rsv_addr_i[ADDR_W-1:PAGE_SH] == ea_i[ADDR_W-1:PAGE_SH]);
    if (!valid_i)       case_o = SC_NONE;
    else if (exact)     case_o = SC_EXACT;
    else if (same_page) case_o = SC_SAME_PAGE;
    else                case_o = SC_OTHER_PG;
  end

  initial assert_page_pow2_R4: assert (PAGE_BYTES == (1 << PAGE_SH));
endmodule

// File: rtl/sc_resv_checker.sv
module sc_resv_checker
  import sc_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 64,
  parameter int LEN_W       = 4,
  parameter int SEL_W       = 5,
  parameter int PAGE_BYTES  = 4096,
  parameter bit AMB_STORE   = 1'b1,
  parameter bit AMB_FLAG    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsv_set_i,
  input  logic [ADDR_W-1:0] rsv_addr_i,
  input  logic [LEN_W-1:0]  rsv_len_i,
  input  logic              sc_req_i,
  input  logic [SEL_W-1:0]  sc_base_sel_i,
  input  logic [ADDR_W-1:0] sc_base_i,
  input  logic [ADDR_W-1:0] sc_index_i,
  input  logic [DATA_W-1:0] sc_src_i,
  input  logic              so_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [3:0]        cr_o,
  output logic              done_o
);
  localparam int STORE_BYTES = 4;
  localparam int ST_W        = STORE_BYTES * 8;

  logic              rsv_valid;
  logic [ADDR_W-1:0] rsv_addr;
  logic [LEN_W-1:0]  rsv_len;
  logic [ADDR_W-1:0] ea;
  sc_case_e          sc_case;
  logic              do_wr, ok;

  sc_resv_reg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_resv (
    .clk_i, .rst_ni,
    .set_i(rsv_set_i), .set_addr_i(rsv_addr_i), .set_len_i(rsv_len_i),
    .clr_i(sc_req_i),
    .valid_o(rsv_valid), .addr_o(rsv_addr), .len_o(rsv_len)
  );

  sc_ea_calc #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ea (
    .base_sel_i(sc_base_sel_i), .base_i(sc_base_i), .index_i(sc_index_i), .ea_o(ea)
  );

  sc_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
             .STORE_BYTES(STORE_BYTES)) u_match (
    .valid_i(rsv_valid), .rsv_addr_i(rsv_addr), .rsv_len_i(rsv_len),
    .ea_i(ea), .case_o(sc_case)
  );

  always_comb begin
    unique case (sc_case)
      SC_EXACT:     begin do_wr = 1'b1;      ok = 1'b1;     end
      SC_SAME_PAGE: begin do_wr = AMB_STORE; ok = AMB_FLAG; end
      default:      begin do_wr = 1'b0;      ok = 1'b0;     end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      cr_o      <= '0;
    end else begin
      done_o  <= sc_req_i;
      wr_en_o <= sc_req_i & do_wr;
      if (sc_req_i) begin
        wr_addr_o <= ea;
        wr_data_o <= sc_src_i[ST_W-1:0];
        cr_o      <= {2'b00, ok, so_i};
      end
    end
  end

  assert_done_follows_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_req_i |=> done_o);
  assert_idle_no_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_req_i |=> !done_o);
  assert_wr_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);
  assert_cr_high_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cr_o[3:2] == 2'b00));
  assert_so_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_req_i |=> (cr_o[0] == $past(so_i)));
  assert_no_resv_no_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_req_i && !rsv_valid) |=> (!wr_en_o && !cr_o[1]));
endmodule

// File: tb/sc_resv_checker_tb.sv
module sc_resv_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PG_SH = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsv_set = 1'b0;
  logic [63:0] rsv_addr = '0;
  logic [3:0]  rsv_len = '0;
  logic        sc_req = 1'b0;
  logic [4:0]  sel = '0;
  logic [63:0] base = '0, idx = '0, src = '0;
  logic        so = 1'b0;
  logic        wr_en, done;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  cr;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_resv_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rsv_set_i(rsv_set), .rsv_addr_i(rsv_addr), .rsv_len_i(rsv_len),
    .sc_req_i(sc_req), .sc_base_sel_i(sel), .sc_base_i(base), .sc_index_i(idx),
    .sc_src_i(src), .so_i(so),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .cr_o(cr), .done_o(done)
  );

  typedef struct {
    logic        wr;
    logic [63:0] addr;
    logic [31:0] data;
    logic [3:0]  cr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench reservation model
  logic        m_v = 1'b0;
  logic [63:0] m_a = '0;
  logic [3:0]  m_l = '0;

  task automatic lr(input logic [63:0] a, input logic [3:0] l);
    rsv_set = 1'b1; rsv_addr = a; rsv_len = l;
    m_v = 1'b1; m_a = a; m_l = l;
    @(negedge clk);
    rsv_set = 1'b0;
  endtask

  task automatic sc(input logic [4:0] s, input logic [63:0] b, input logic [63:0] i,
                    input logic [63:0] d, input logic o, input logic with_lr,
                    input logic [63:0] la, input logic [3:0] ll, input string tag);
    exp_t e;
    logic [63:0] ea;
    logic okb, wrb;
    ea = (s == 5'd0) ? i : b + i;                       // R1
    if (!m_v) begin wrb = 0; okb = 0; end               // R5
    else if (m_l == 4'd4 && m_a == ea) begin wrb = 1; okb = 1; end  // R2
    else if ((m_a >> PG_SH) == (ea >> PG_SH)) begin wrb = 1; okb = 1; end // R6 defaults
    else begin wrb = 0; okb = 0; end                    // R4
    e.wr = wrb; e.addr = ea; e.data = d[31:0]; e.cr = {2'b00, okb, o}; e.tag = tag;
    sb.push_back(e);
    m_v = 1'b0;                                         // R7
    sc_req = 1'b1; sel = s; base = b; idx = i; src = d; so = o;
    if (with_lr) begin                                  // R8
      rsv_set = 1'b1; rsv_addr = la; rsv_len = ll;
      m_v = 1'b1; m_a = la; m_l = ll;
    end
    @(negedge clk);
    sc_req = 1'b0; rsv_set = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || wr_en !== 1'b0) begin
      errors++;
      $display("FAIL %s: done=%b wr_en=%b expected 0 0", tag, done, wr_en);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en && !done) begin
        errors++;
        $display("FAIL R9: wr_en=1 with done=0, expected done=1");
      end
      if (done) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R9: done=1 with no request, expected done=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (wr_en !== e.wr || cr !== e.cr ||
              (e.wr && (wr_addr !== e.addr || wr_data !== e.data))) begin
            errors++;
            $display("FAIL %s: wr=%b cr=%b addr=%h data=%h expected wr=%b cr=%b addr=%h data=%h",
                     e.tag, wr_en, cr, wr_addr, wr_data, e.wr, e.cr, e.addr, e.data);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 0 || wr_en !== 0 || cr !== 4'h0) begin
      errors++;
      $display("FAIL R10: done=%b wr_en=%b cr=%b expected 0 0 0000", done, wr_en, cr);
    end
    // R10/R5: nothing reserved after reset
    sc(5'd3, 64'h1000, 64'h20, 64'h1111_2222_3333_4444, 1'b0, 0, 0, 0, "R10_R5 no reservation");
    idle_check("R9 single pulse");
    // R2 exact match, base+index
    lr(64'h0000_0000_0001_2340, 4'd4);
    sc(5'd4, 64'h0000_0000_0001_2000, 64'h340, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 0, 0, 0, "R2 exact match");
    // R7: reservation dropped after success
    sc(5'd4, 64'h0000_0000_0001_2000, 64'h340, 64'h0123_4567_89AB_CDEF, 1'b0, 0, 0, 0, "R7 cleared after success");
    // R1: zero select ignores base
    lr(64'h0000_0000_0000_5008, 4'd4);
    sc(5'd0, 64'hFFFF_0000_1234_0000, 64'h5008, 64'h0000_0000_AAAA_5555, 1'b0, 0, 0, 0, "R1 zero base select");
    // R3: summary-overflow bit passes through
    lr(64'h0000_0000_0000_7000, 4'd4);
    sc(5'd1, 64'h7000, 64'h0, 64'h0000_0000_1357_9BDF, 1'b1, 0, 0, 0, "R3 so on success");
    sc(5'd1, 64'h7000, 64'h0, 64'h0, 1'b1, 0, 0, 0, "R3 so on fail");
    // R6: wrong length, same address
    lr(64'h0000_0000_0000_9100, 4'd8);
    sc(5'd2, 64'h9000, 64'h100, 64'h0000_0000_0BAD_F00D, 1'b0, 0, 0, 0, "R6 length mismatch same page");
    // R6: neighbouring word in same page
    lr(64'h0000_0000_0000_9100, 4'd4);
    sc(5'd2, 64'h9000, 64'h108, 64'h0000_0000_7777_8888, 1'b1, 0, 0, 0, "R6 address mismatch same page");
    // R7: cleared after same-page case
    sc(5'd2, 64'h9000, 64'h108, 64'h0, 1'b0, 0, 0, 0, "R7 cleared after same-page");
    // R4: different page
    lr(64'h0000_0000_0000_9100, 4'd4);
    sc(5'd2, 64'h9000, 64'h2100, 64'h0000_0000_4444_3333, 1'b0, 0, 0, 0, "R4 other page");
    // R4: page boundary
    lr(64'h0000_0000_0000_1FFC, 4'd4);
    sc(5'd0, 64'h0, 64'h2000, 64'h0000_0000_9999_0000, 1'b0, 0, 0, 0, "R4 page boundary");
    // R7: cleared after a fail
    sc(5'd0, 64'h0, 64'h1FFC, 64'h0, 1'b0, 0, 0, 0, "R7 cleared after fail");
    // R8: reserve and request together
    sc(5'd6, 64'hA000, 64'h40, 64'h0000_0000_5A5A_A5A5, 1'b0, 1, 64'h0000_0000_0000_A040, 4'd4, "R8 same-cycle uses old state");
    sc(5'd6, 64'hA000, 64'h40, 64'h0000_0000_C3C3_3C3C, 1'b0, 0, 0, 0, "R8 new reservation stands");
    // R8: same-cycle with a held reservation: old one used
    lr(64'h0000_0000_0000_B000, 4'd4);
    sc(5'd0, 64'h0, 64'hB000, 64'h0000_0000_1234_5678, 1'b0, 1, 64'h0000_0000_0003_0000, 4'd4, "R8 old reservation hit");
    sc(5'd0, 64'h0, 64'h3_0000, 64'h0000_0000_8765_4321, 1'b1, 0, 0, 0, "R8 follow-up on new reservation");
    idle_check("R9 no trailing done");
    repeat (2) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing, expected 0", sb.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule